// File: doc/BRIEF.md
# DMA Channel Control and Status Register

This block keeps the 16-bit control and status word of one DMA channel. Software changes it with a masked write: one 32-bit data word carries a per-bit mask and a new value, and only the bits picked by the mask take the new value. The engine that walks the channel's command list updates the word from the other side. It drives three indications (engine dead, engine active, branch taken) and it can set or clear any of the eight device-status bits.

The upper byte carries the run-state bits. Run, pause, flush and wake are owned by software and go out as request levels to the sequencer. Dead, active and branch are owned by the engine. The lower byte is device-dependent status. Both writers share it, and on a per-bit collision the hardware wins. Flush is a request that clears itself: it stays set until the engine acknowledges that pending data has been written out. Clearing run stops the channel and drops the active bit in the same update.

Top module: `dma_chan_csr`

## Requirements
- R1: After a synchronous reset the status word reads 0x0000 and all four request outputs are 0.
- R2: A software write takes the mask from bits 31:16 of the data word and the value from bits 15:0. The update appears on the status word one cycle later. Bits 15:12 and 7:0 whose mask bit is 1 take the value bit, and bits whose mask bit is 0 keep their contents.
- R3: Software writes never change bits 11:8. Bit 9 always reads 0.
- R4: Bit 11 (dead) and bit 8 (branch taken) show the engine's dead and branch indications as they were one cycle earlier.
- R5: Bit 10 (active) shows the engine's active indication one cycle later, but only while run (bit 15) is also 1 after that update. A write that clears run clears active in the same update.
- R6: Flush (bit 13) set by software stays 1 until the engine pulses flush acknowledge, and then reads 0 one cycle later. An acknowledge in the same cycle as a software write that sets flush leaves flush at 0.
- R7: The hardware set input sets device-status bits to 1 and the clear input sets them to 0. Where both are 1 on one bit, set wins.
- R8: When hardware sets or clears a device-status bit in the same cycle as a software write that selects that bit, the hardware result is kept. Other bits selected by the write still take the software value.
- R9: The run, pause, flush and wake request outputs equal status bits 15, 14, 13 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr_en | input | 1 | Software masked-write strobe |
| sw_wr_data | input | 32 | Mask in 31:16, value in 15:0 |
| hw_dev_set | input | 8 | Hardware set of device-status bits |
| hw_dev_clr | input | 8 | Hardware clear of device-status bits |
| eng_dead | input | 1 | Engine dead indication |
| eng_active | input | 1 | Engine active indication |
| eng_branch | input | 1 | Engine branch-taken indication |
| eng_flush_ack | input | 1 | Engine acknowledge that flush finished |
| csr_status | output | 16 | Current control/status word |
| run_req | output | 1 | Run request to sequencer |
| pause_req | output | 1 | Pause request to sequencer |
| flush_req | output | 1 | Flush request to sequencer |
| wake_req | output | 1 | Wake request to sequencer |

## Verification
The masked write is tried with three mask shapes: a full low byte, a two-bit mask with value zero, and a mask over the read-only bits. These show whether unselected bits are kept and whether engine-owned bits are shielded. Engine indications are stepped with run both set and clear, which tells a plain copy of active apart from one gated by run. Software and hardware writes are made to collide on device bits and on flush, which shows whether hardware priority applies per bit and whether writes to other bits still go through.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
    localparam int CSR_W   = 16;
    localparam int DEV_W   = 8;
    localparam int WR_W    = 2 * CSR_W;
    localparam int CTL_W   = 4;
    localparam int CTL_LSB = CSR_W - CTL_W;

    localparam int POS_RUN    = 15;
    localparam int POS_PAUSE  = 14;
    localparam int POS_FLUSH  = 13;
    localparam int POS_WAKE   = 12;
    localparam int POS_DEAD   = 11;
    localparam int POS_ACTIVE = 10;
    localparam int POS_BRANCH = 8;

    typedef struct packed {
        logic [CSR_W-1:0] mask;
        logic [CSR_W-1:0] value;
    } sw_write_t;

    typedef struct packed {
        logic run;
        logic pause;
        logic flush;
        logic wake;
    } ctl_bits_t;

    typedef struct packed {
        logic dead;
        logic active;
        logic branch;
    } eng_ind_t;

    function automatic logic [CSR_W-1:0] merge_masked(
        input logic [CSR_W-1:0] old_w,
        input logic [CSR_W-1:0] mask,
        input logic [CSR_W-1:0] value
    );
        return (old_w & ~mask) | (value & mask);
    endfunction
endpackage

// File: rtl/csr_run_ctl.sv
module csr_run_ctl
    import dma_csr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sw_en,
    input  sw_write_t wr,
    input  logic      flush_ack,
    input  logic      eng_dead,
    input  logic      eng_active,
    input  logic      eng_branch,
    output ctl_bits_t ctl_q,
    output eng_ind_t  ind_q
);
    logic [CSR_W-1:0] merged;
    ctl_bits_t        ctl_next;
    eng_ind_t         ind_next;

    always_comb begin
        merged   = merge_masked({ctl_q, {CTL_LSB{1'b0}}}, wr.mask, wr.value);
        ctl_next = ctl_q;
        if (sw_en) begin
            ctl_next = ctl_bits_t'(merged[CSR_W-1:CTL_LSB]);
        end
        if (flush_ack) begin
            ctl_next.flush = 1'b0;
        end
        ind_next.dead   = eng_dead;
        ind_next.active = eng_active & ctl_next.run;
        ind_next.branch = eng_branch;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            ind_q <= '0;
        end else begin
            ctl_q <= ctl_next;
            ind_q <= ind_next;
        end
    end

    // R5: active can only be shown while the channel is running
    assert_active_needs_run_R5: assert property (@(posedge clk) disable iff (rst)
        ind_q.active |-> ctl_q.run);

    // R6: an acknowledge always leaves flush low
    assert_flush_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
        flush_ack |=> !ctl_q.flush);

    // R3: dead follows the engine regardless of software writes
    assert_dead_tracks_engine_R3: assert property (@(posedge clk) disable iff (rst)
        sw_en |=> (ind_q.dead == $past(eng_dead)));
endmodule

// File: rtl/csr_dev_status.sv
module csr_dev_status #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sw_en,
    input  logic [W-1:0] sw_mask,
    input  logic [W-1:0] sw_value,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] hw_clr,
    output logic [W-1:0] dev_q
);
    logic [W-1:0] dev_next;

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign dev_next[g] = hw_set[g]              ? 1'b1 :
                             hw_clr[g]              ? 1'b0 :
                             (sw_en && sw_mask[g])  ? sw_value[g] :
                                                      dev_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) dev_q <= '0;
        else     dev_q <= dev_next;
    end

    // R7: every bit the hardware sets reads 1 next cycle
    assert_hw_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> ((dev_q & $past(hw_set)) == $past(hw_set)));

    // R8: a cleared bit not also set reads 0 next cycle, whatever software wrote
    assert_hw_clr_beats_sw_R8: assert property (@(posedge clk) disable iff (rst)
        ((hw_clr & ~hw_set) != '0) |=> ((dev_q & $past(hw_clr & ~hw_set)) == '0));

    // R2: with no writer active the byte holds
    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (!sw_en && hw_set == '0 && hw_clr == '0) |=> $stable(dev_q));
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
    import dma_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_wr_en,
    input  logic [WR_W-1:0]   sw_wr_data,
    input  logic [DEV_W-1:0]  hw_dev_set,
    input  logic [DEV_W-1:0]  hw_dev_clr,
    input  logic              eng_dead,
    input  logic              eng_active,
    input  logic              eng_branch,
    input  logic              eng_flush_ack,
    output logic [CSR_W-1:0]  csr_status,
    output logic              run_req,
    output logic              pause_req,
    output logic              flush_req,
    output logic              wake_req
);
    sw_write_t       wr;
    ctl_bits_t       ctl;
    eng_ind_t        ind;
    logic [DEV_W-1:0] dev;

    assign wr = sw_write_t'(sw_wr_data);

    csr_run_ctl u_run_ctl (
        .clk        (clk),
        .rst        (rst),
        .sw_en      (sw_wr_en),
        .wr         (wr),
        .flush_ack  (eng_flush_ack),
        .eng_dead   (eng_dead),
        .eng_active (eng_active),
        .eng_branch (eng_branch),
        .ctl_q      (ctl),
        .ind_q      (ind)
    );

    csr_dev_status #(.W(DEV_W)) u_dev (
        .clk      (clk),
        .rst      (rst),
        .sw_en    (sw_wr_en),
        .sw_mask  (wr.mask[DEV_W-1:0]),
        .sw_value (wr.value[DEV_W-1:0]),
        .hw_set   (hw_dev_set),
        .hw_clr   (hw_dev_clr),
        .dev_q    (dev)
    );

    always_comb begin
        csr_status             = '0;
        csr_status[POS_RUN]    = ctl.run;
        csr_status[POS_PAUSE]  = ctl.pause;
        csr_status[POS_FLUSH]  = ctl.flush;
        csr_status[POS_WAKE]   = ctl.wake;
        csr_status[POS_DEAD]   = ind.dead;
        csr_status[POS_ACTIVE] = ind.active;
        csr_status[POS_BRANCH] = ind.branch;
        csr_status[DEV_W-1:0]  = dev;
    end

    assign run_req   = ctl.run;
    assign pause_req = ctl.pause;
    assign flush_req = ctl.flush;
    assign wake_req  = ctl.wake;

    // R4: branch-taken shows the engine indication one cycle later
    assert_branch_follows_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (csr_status[POS_BRANCH] == $past(eng_branch)));

    // R2: an unmasked write leaves the run-state control bits alone
    assert_unmasked_ctl_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (sw_wr_en && wr.mask[CSR_W-1:CTL_LSB] == '0 && !eng_flush_ack)
        |=> $stable(csr_status[CSR_W-1:CTL_LSB]));
endmodule

// File: tb/dma_chan_csr_bench.sv
`timescale 1ns/1ps
module dma_chan_csr_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        sw_wr_en;
    logic [31:0] sw_wr_data;
    logic [7:0]  hw_dev_set, hw_dev_clr;
    logic        eng_dead, eng_active, eng_branch, eng_flush_ack;
    logic [15:0] csr_status;
    logic        run_req, pause_req, flush_req, wake_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dma_chan_csr u_dma_chan_csr (
        .clk(clk), .rst(rst), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .hw_dev_set(hw_dev_set), .hw_dev_clr(hw_dev_clr),
        .eng_dead(eng_dead), .eng_active(eng_active), .eng_branch(eng_branch),
        .eng_flush_ack(eng_flush_ack), .csr_status(csr_status),
        .run_req(run_req), .pause_req(pause_req), .flush_req(flush_req),
        .wake_req(wake_req)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] wd;
        logic [7:0]  hs;
        logic [7:0]  hc;
        logic        dead;
        logic        act;
        logic        br;
        logic        ack;
        logic [15:0] exp;
        logic [3:0]  req;   // {run, pause, flush, wake}
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h00FF_00A5, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h00A5, 4'b0000}, // R2 low byte
        '{1'b1, 32'h0003_0000, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h00A4, 4'b0000}, // R2 mask 0x03 value 0
        '{1'b1, 32'h8000_8000, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h80A4, 4'b1000}, // R9 run
        '{1'b0, 32'h0000_0000, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 16'h84A4, 4'b1000}, // R5 active
        '{1'b1, 32'h0F00_0F00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 16'h84A4, 4'b1000}, // R3 read-only
        '{1'b0, 32'h0000_0000, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 16'h8DA4, 4'b1000}, // R4 dead+branch
        '{1'b0, 32'h0000_0000, 8'h01, 8'h80, 1'b0, 1'b1, 1'b0, 1'b0, 16'h8425, 4'b1000}, // R7 set/clear
        '{1'b1, 32'h00FF_0000, 8'h04, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 16'h8404, 4'b1000}, // R8 hw over sw
        '{1'b1, 32'h2000_2000, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 16'hA404, 4'b1010}, // R6 flush set
        '{1'b0, 32'h0000_0000, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 16'hA404, 4'b1010}, // R6 flush held
        '{1'b0, 32'h0000_0000, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 16'h8404, 4'b1000}, // R6 ack
        '{1'b1, 32'h2000_2000, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 16'h8404, 4'b1000}, // R6 ack wins
        '{1'b1, 32'h8000_0000, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0004, 4'b0000}, // R5 run cleared
        '{1'b0, 32'h0000_0000, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0004, 4'b0000}, // R5 stays gated
        '{1'b1, 32'h5000_FFFF, 8'h08, 8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 16'h500C, 4'b0101}, // R7 set beats clear, R9
        '{1'b1, 32'h0010_0010, 8'h00, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 16'h500C, 4'b0101}  // R8 clear beats sw
    };

    task automatic idle_inputs();
        sw_wr_en = 1'b0; sw_wr_data = '0; hw_dev_set = '0; hw_dev_clr = '0;
        eng_dead = 1'b0; eng_active = 1'b0; eng_branch = 1'b0; eng_flush_ack = 1'b0;
    endtask

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check16("R1 reset status", csr_status, 16'h0000);
        check16("R1 reset requests", {12'h0, run_req, pause_req, flush_req, wake_req}, 16'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            sw_wr_en      = VECS[i].wr;
            sw_wr_data    = VECS[i].wd;
            hw_dev_set    = VECS[i].hs;
            hw_dev_clr    = VECS[i].hc;
            eng_dead      = VECS[i].dead;
            eng_active    = VECS[i].act;
            eng_branch    = VECS[i].br;
            eng_flush_ack = VECS[i].ack;
            @(negedge clk);
            check16($sformatf("vector %0d status (R2 R3 R4 R5 R6 R7 R8)", i),
                    csr_status, VECS[i].exp);
            check16($sformatf("vector %0d R9 requests", i),
                    {12'h0, run_req, pause_req, flush_req, wake_req}, {12'h0, VECS[i].req});
        end

        // R1: reset from a busy state
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        check16("R1 reset mid-run", csr_status, 16'h0000);
        rst = 1'b0;

        // R3: bit 9 cannot be set by software even with a full mask
        sw_wr_en = 1'b1; sw_wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        idle_inputs();
        check16("R3 full write", csr_status, 16'hF0FF);

        // R6: flush persists over several idle cycles without acknowledge
        repeat (3) @(negedge clk);
        check16("R6 flush persists", csr_status, 16'hF0FF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule